// File: doc/BRIEF.md
# Descriptor-Driven Display Refresh DMA Channel

This block is one display-refresh read channel. Software stores frame descriptors in memory. Each descriptor is three 32-bit words: a buffer address, a control word and a next pointer. The channel fetches a descriptor and then reads the frame's words from the buffer. It passes each word out on a pixel-word stream. When the frame ends, it either follows the next pointer, switches to a newly queued descriptor, or stops. Memory is reached over a simple request/response read port that has a valid/ready request side, one outstanding request at most, and a one-cycle response pulse.

A small register interface controls the channel. It carries four single-cycle command strobes: start, stop-after-frame, immediate kill and link-queued-descriptor. It also holds the head-descriptor address, the frame length in words and the pixel format, and it gives a status word with a busy bit. Sticky interrupt flags clear on read, and a mask selects which flags drive the interrupt line. Once the first descriptor word is known, the channel checks the buffer address against the alignment that the selected pixel format needs.

Top module: `disp_dma_chan`

## Requirements
- R1: After reset the status reads 0, the flag register reads 0, `irq` is low and no memory request is made.
- R2: Writing 1 to control bit 0 while idle fetches the descriptor at the head address. It reads the address word at head, the control word at head+4 and the next word at head+8, in that order. It then reads `frame size` words at buffer+4k for k = 0, 1, 2 and so on, and presents each returned word on `pix_data` with `pix_valid`, in order.
- R3: At most one read request is outstanding. A request that is not yet accepted keeps `mem_req_valid` high and its address stable.
- R4: At frame end, if the descriptor's next word has bit 0 clear, the channel fetches the next descriptor from that address.
- R5: If bit 0 of the descriptor's control word is 0, the channel completes the frame, sets the terminated flag and clears busy.
- R6: If bit 0 of the next word is 1, the channel completes the frame and then stops instead of fetching again.
- R7: Writing 1 to control bit 1 during a frame lets that frame complete in full, after which the channel stops and sets the terminated flag.
- R8: Writing 1 to control bit 2 stops the channel at once and makes no further requests. The response to an outstanding read is discarded and never appears on `pix_data`. Busy stays 1 until that response has arrived. The terminated flag is not set.
- R9: Writing 1 to control bit 3 while active sets the queued flag. At the next frame end the channel fetches the descriptor at the head register instead of the next pointer, unless a stop condition applies. The loaded flag is set whenever a descriptor fetched from the head register (at start or by a link) is accepted. A link while idle has no effect.
- R10: The flag bits are: bit 0 frame completed, bit 1 descriptor loaded from head, bit 2 descriptor queued, bit 3 terminated, bit 4 misaligned buffer. The flags are sticky and a read of the flag register clears them. An event in the same cycle as the read is kept.
- R11: `irq` is high exactly when some flag is set whose mask bit is 1.
- R12: The format field selects the alignment. Codes 0-3 (palette) and 10, 12 (packed 18/19 bpp) need byte alignment. Codes 4-8 (12/16 bpp) need 16-bit alignment. Codes 9, 11, 13 and above (unpacked 18/19 bpp, 24 bpp) need 32-bit alignment. A misaligned buffer address sets the misaligned flag and stops the channel without frame reads or the loaded or terminated flags.
- R13: The register offsets (`reg_addr`) are: 0 command strobes (write), 1 head address, 2 frame size in words, 3 status (bit 0 busy), 4 flags, 5 mask, 6 format. Registers 1, 2, 5 and 6 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags when offset 4) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked interrupt |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Read byte address |
| mem_rsp_valid | input | 1 | Read response pulse |
| mem_rsp_data | input | 32 | Read response word |
| pix_valid | output | 1 | Frame word valid |
| pix_data | output | 32 | Frame word |

## Verification
The assertions assume that the memory returns exactly one response for each accepted request and never returns one unprompted. They also assume that register strobes last one cycle and that the frame size and format do not change while a descriptor is being fetched. The bench memory model keeps a single pending slot that follows each accepted request, with a latency that can be programmed. It may withhold ready, which exercises the hold rule. The bench writes size and format only while the channel is idle.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
   localparam int WORD_W     = 32;
   localparam int FMT_W      = 4;
   localparam int REG_AW     = 3;
   localparam int DESC_WORDS = 3;

   typedef enum logic [1:0] {CH_IDLE, CH_FETCH, CH_XFER} ch_state_e;

   localparam int FLAG_FRAME = 0;
   localparam int FLAG_LOAD  = 1;
   localparam int FLAG_QUEUE = 2;
   localparam int FLAG_TERM  = 3;
   localparam int FLAG_ALIGN = 4;
   localparam int NUM_FLAGS  = 5;

   localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
   localparam logic [REG_AW-1:0] RA_HEAD = 3'd1;
   localparam logic [REG_AW-1:0] RA_SIZE = 3'd2;
   localparam logic [REG_AW-1:0] RA_STAT = 3'd3;
   localparam logic [REG_AW-1:0] RA_FLAG = 3'd4;
   localparam logic [REG_AW-1:0] RA_MASK = 3'd5;
   localparam logic [REG_AW-1:0] RA_FMT  = 3'd6;

   localparam int CMD_RUN  = 0;
   localparam int CMD_STOP = 1;
   localparam int CMD_KILL = 2;
   localparam int CMD_LINK = 3;

   // Low address bits that must be zero for a given pixel format code
   function automatic logic [1:0] align_mask(input logic [FMT_W-1:0] fmt);
      if (fmt <= 4'd3)                     return 2'b00;
      else if (fmt <= 4'd8)                return 2'b01;
      else if (fmt == 4'd10 || fmt == 4'd12) return 2'b00;
      else                                 return 2'b11;
   endfunction
endpackage

// File: rtl/ddc_regs.sv
module ddc_regs
   import ddc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   output logic                 go,
   output logic                 stop,
   output logic                 kill,
   output logic                 link,
   output logic [ADDR_W-1:0]    head_addr,
   output logic [SIZE_W-1:0]    frame_words,
   output logic [FMT_W-1:0]     pix_fmt,
   input  logic                 busy,
   input  logic [NUM_FLAGS-1:0] evt,
   output logic                 irq
);
   logic [NUM_FLAGS-1:0] flags_q, mask_q;
   logic                 wr_cmd, rd_clr;

   assign wr_cmd = reg_wr && (reg_addr == RA_CTRL);
   assign go     = wr_cmd && reg_wdata[CMD_RUN];
   assign stop   = wr_cmd && reg_wdata[CMD_STOP];
   assign kill   = wr_cmd && reg_wdata[CMD_KILL];
   assign link   = wr_cmd && reg_wdata[CMD_LINK];
   assign rd_clr = reg_rd && (reg_addr == RA_FLAG);
   assign irq    = |(flags_q & mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_addr   <= '0;
         frame_words <= '0;
         pix_fmt     <= '0;
         mask_q      <= '0;
         flags_q     <= '0;
      end else begin
         if (reg_wr) begin
            unique case (reg_addr)
               RA_HEAD: head_addr   <= reg_wdata[ADDR_W-1:0];
               RA_SIZE: frame_words <= reg_wdata[SIZE_W-1:0];
               RA_MASK: mask_q      <= reg_wdata[NUM_FLAGS-1:0];
               RA_FMT:  pix_fmt     <= reg_wdata[FMT_W-1:0];
               default: ;
            endcase
         end
         flags_q <= (rd_clr ? '0 : flags_q) | evt;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_HEAD: reg_rdata[ADDR_W-1:0]    = head_addr;
         RA_SIZE: reg_rdata[SIZE_W-1:0]    = frame_words;
         RA_STAT: reg_rdata[0]             = busy;
         RA_FLAG: reg_rdata[NUM_FLAGS-1:0] = flags_q;
         RA_MASK: reg_rdata[NUM_FLAGS-1:0] = mask_q;
         RA_FMT:  reg_rdata[FMT_W-1:0]     = pix_fmt;
         default: reg_rdata = '0;
      endcase
   end

   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[FLAG_TERM] |=> flags_q[FLAG_TERM]);
   // R10
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && evt == '0) |=> (flags_q == '0));
endmodule

// File: rtl/ddc_engine.sv
module ddc_engine
   import ddc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic                 stop,
   input  logic                 kill,
   input  logic                 link,
   input  logic [ADDR_W-1:0]    head_addr,
   input  logic [SIZE_W-1:0]    frame_words,
   input  logic [FMT_W-1:0]     pix_fmt,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [ADDR_W-1:0]    mem_req_addr,
   input  logic                 mem_rsp_valid,
   input  logic [WORD_W-1:0]    mem_rsp_data,
   output logic                 pix_valid,
   output logic [WORD_W-1:0]    pix_data,
   output logic                 busy,
   output logic [NUM_FLAGS-1:0] evt
);
   localparam logic [SIZE_W-1:0] DESC_LEN = SIZE_W'(DESC_WORDS);

   ch_state_e         state_q;
   logic              wait_q, drop_q, stop_q, link_q, head_q, run_q;
   logic [SIZE_W-1:0] cnt_q, len_q;
   logic [ADDR_W-1:0] ptr_q, buf_q, next_q, w0_q;
   logic              live, rsp_take, accept, fetch_last, frame_end, quit, align_ok;

   assign live          = (state_q != CH_IDLE);
   assign busy          = live || drop_q;
   assign rsp_take      = mem_rsp_valid && wait_q;
   assign mem_req_valid = !wait_q && !drop_q &&
                          ((state_q == CH_FETCH && cnt_q < DESC_LEN) ||
                           (state_q == CH_XFER  && cnt_q < len_q));
   assign mem_req_addr  = ((state_q == CH_FETCH) ? ptr_q : buf_q) + (ADDR_W'(cnt_q) << 2);
   assign accept        = mem_req_valid && mem_req_ready;
   assign fetch_last    = !kill && state_q == CH_FETCH && rsp_take && cnt_q == DESC_LEN - 1'b1;
   assign frame_end     = !kill && state_q == CH_XFER && !wait_q && cnt_q == len_q;
   assign quit          = stop_q || !run_q || next_q[0];
   assign align_ok      = (w0_q[1:0] & align_mask(pix_fmt)) == 2'b00;
   assign pix_valid     = (state_q == CH_XFER) && rsp_take;
   assign pix_data      = mem_rsp_data;

   always_comb begin
      evt             = '0;
      evt[FLAG_FRAME] = frame_end;
      evt[FLAG_TERM]  = frame_end && quit;
      evt[FLAG_LOAD]  = fetch_last && align_ok && head_q;
      evt[FLAG_ALIGN] = fetch_last && !align_ok;
      evt[FLAG_QUEUE] = link && live && !kill;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CH_IDLE;
         wait_q  <= 1'b0;
         drop_q  <= 1'b0;
         stop_q  <= 1'b0;
         link_q  <= 1'b0;
         head_q  <= 1'b0;
         run_q   <= 1'b0;
         cnt_q   <= '0;
         len_q   <= '0;
         ptr_q   <= '0;
         buf_q   <= '0;
         next_q  <= '0;
         w0_q    <= '0;
      end else if (kill) begin
         state_q <= CH_IDLE;
         wait_q  <= 1'b0;
         drop_q  <= ((wait_q || drop_q) && !mem_rsp_valid) || accept;
         stop_q  <= 1'b0;
         link_q  <= 1'b0;
      end else begin
         if (drop_q && mem_rsp_valid) drop_q <= 1'b0;
         if (accept)                  wait_q <= 1'b1;
         if (rsp_take) begin
            wait_q <= 1'b0;
            cnt_q  <= cnt_q + 1'b1;
         end
         if (stop && live) stop_q <= 1'b1;
         if (link && live) link_q <= 1'b1;
         unique case (state_q)
            CH_IDLE: if (go && !drop_q) begin
               state_q <= CH_FETCH;
               ptr_q   <= head_addr;
               head_q  <= 1'b1;
               cnt_q   <= '0;
            end
            CH_FETCH: if (rsp_take) begin
               if (cnt_q == '0) w0_q <= mem_rsp_data[ADDR_W-1:0];
               else if (cnt_q == 1) run_q <= mem_rsp_data[0];
               else begin
                  next_q <= mem_rsp_data[ADDR_W-1:0];
                  buf_q  <= w0_q;
                  len_q  <= frame_words;
                  cnt_q  <= '0;
                  if (align_ok) state_q <= CH_XFER;
                  else begin
                     state_q <= CH_IDLE;
                     stop_q  <= 1'b0;
                     link_q  <= 1'b0;
                  end
               end
            end
            CH_XFER: if (frame_end) begin
               cnt_q <= '0;
               if (quit) begin
                  state_q <= CH_IDLE;
                  stop_q  <= 1'b0;
                  link_q  <= 1'b0;
               end else begin
                  state_q <= CH_FETCH;
                  if (link_q) begin
                     ptr_q  <= head_addr;
                     head_q <= 1'b1;
                     link_q <= 1'b0;
                  end else begin
                     ptr_q  <= next_q;
                     head_q <= 1'b0;
                  end
               end
            end
            default: state_q <= CH_IDLE;
         endcase
      end
   end

   // R3
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !mem_req_valid);
   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready && !kill) |=> (mem_req_valid && $stable(mem_req_addr)));
   // R8
   kill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (!mem_req_valid && !pix_valid));
   // R8
   kill_drain_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill && wait_q && !mem_rsp_valid) |=> busy);
   // R2
   pix_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> busy);
endmodule

// File: rtl/disp_dma_chan.sv
module disp_dma_chan
   import ddc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   output logic              pix_valid,
   output logic [31:0]       pix_data
);
   generate
      if (ADDR_W < 8 || ADDR_W > WORD_W) begin : g_bad_addr_w
         $error("disp_dma_chan: ADDR_W must lie in 8..32");
      end
      if (SIZE_W < 2 || SIZE_W > 24) begin : g_bad_size_w
         $error("disp_dma_chan: SIZE_W must lie in 2..24");
      end
   endgenerate

   logic                 go, stop, kill, link, busy;
   logic [ADDR_W-1:0]    head_addr;
   logic [SIZE_W-1:0]    frame_words;
   logic [FMT_W-1:0]     pix_fmt;
   logic [NUM_FLAGS-1:0] evt;

   ddc_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .go(go), .stop(stop), .kill(kill), .link(link),
      .head_addr(head_addr), .frame_words(frame_words), .pix_fmt(pix_fmt),
      .busy(busy), .evt(evt), .irq(irq)
   );

   ddc_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .go(go), .stop(stop), .kill(kill), .link(link),
      .head_addr(head_addr), .frame_words(frame_words), .pix_fmt(pix_fmt),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .pix_valid(pix_valid), .pix_data(pix_data),
      .busy(busy), .evt(evt)
   );
endmodule

// File: tb/disp_dma_chan_bench.sv
`timescale 1ns/100ps
module disp_dma_chan_bench;
   localparam logic [2:0] A_CMD = 3'd0, A_HEAD = 3'd1, A_SIZE = 3'd2, A_STAT = 3'd3,
                          A_FLAG = 3'd4, A_MASK = 3'd5, A_FMT = 3'd6;
   // {format, address low bits, aligned?}
   localparam logic [6:0] ALN_TAB [0:12] = '{
      {4'd0, 2'd1, 1'b1}, {4'd3, 2'd3, 1'b1}, {4'd4, 2'd1, 1'b0}, {4'd4, 2'd2, 1'b1},
      {4'd6, 2'd2, 1'b1}, {4'd8, 2'd1, 1'b0}, {4'd9, 2'd2, 1'b0}, {4'd9, 2'd0, 1'b1},
      {4'd10, 2'd3, 1'b1}, {4'd11, 2'd2, 1'b0}, {4'd12, 2'd1, 1'b1}, {4'd13, 2'd2, 1'b0},
      {4'd13, 2'd0, 1'b1}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic irq, mem_req_valid, mem_req_ready, mem_rsp_valid = 1'b0, pix_valid;
   logic [31:0] mem_req_addr, mem_rsp_data = '0, pix_data;

   disp_dma_chan u_disp_dma_chan (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .pix_valid(pix_valid), .pix_data(pix_data));

   always #2.5 clk = ~clk;

   // memory model: one pending slot, programmable latency, optional ready gaps
   logic [31:0] mem [0:255];
   logic pend = 1'b0, tog = 1'b0, rdy_all = 1'b1;
   logic [7:0] pend_idx = '0;
   int lat_cfg = 1, lat_cnt = 0;
   assign mem_req_ready = rdy_all | tog;
   always @(posedge clk) begin
      tog <= ~tog;
      mem_rsp_valid <= 1'b0;
      if (pend) begin
         if (lat_cnt == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem[pend_idx];
            pend <= 1'b0;
         end else lat_cnt <= lat_cnt - 1;
      end else if (rst_n && mem_req_valid && mem_req_ready) begin
         pend <= 1'b1;
         pend_idx <= mem_req_addr[9:2];
         lat_cnt <= lat_cfg;
      end
   end

   logic [31:0] pix_log [0:511];
   logic [31:0] req_log [0:511];
   int pix_n = 0, req_n = 0;
   always @(posedge clk) begin
      if (pix_valid) begin pix_log[pix_n & 511] <= pix_data; pix_n <= pix_n + 1; end
      if (mem_req_valid && mem_req_ready) begin req_log[req_n & 511] <= mem_req_addr; req_n <= req_n + 1; end
   end

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] s;
      int n = 0;
      do begin reg_read(A_STAT, s); n++; end while (s[0] && n < 3000);
      chk(tag, s, 32'd0);
   endtask

   task automatic put_desc(input int at, input logic [31:0] b, input logic [31:0] c, input logic [31:0] nx);
      mem[at >> 2] = b; mem[(at >> 2) + 1] = c; mem[(at >> 2) + 2] = nx;
   endtask

   task automatic wait_pix(input int target);
      while (pix_n < target) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      int p0, r0;
      for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 | i;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 mem_req_valid in reset", {31'd0, mem_req_valid}, 0);
      rst_n = 1'b1;
      reg_read(A_STAT, v); chk("R1 status", v, 0);
      reg_read(A_FLAG, v); chk("R1 flags", v, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      // R13 register readback
      reg_write(A_HEAD, 32'h0000_0020); reg_read(A_HEAD, v); chk("R13 head readback", v, 32'h20);
      reg_write(A_SIZE, 32'd2); reg_read(A_SIZE, v); chk("R13 size readback", v, 2);

      // R12 alignment table walk, 2-word frames, single descriptor with run bit clear
      reg_write(A_HEAD, 32'h0);
      for (int i = 0; i < 13; i++) begin
         reg_write(A_FMT, {28'd0, ALN_TAB[i][6:3]});
         put_desc(0, 32'h100 | {30'd0, ALN_TAB[i][2:1]}, 32'h0, 32'h0);
         p0 = pix_n;
         reg_write(A_CMD, 32'h1);
         wait_idle("R12 idle");
         reg_read(A_FLAG, v);
         chk($sformatf("R12 flags vec %0d", i), v, ALN_TAB[i][0] ? 32'h0B : 32'h10);
         chk($sformatf("R12 words vec %0d", i), pix_n - p0, ALN_TAB[i][0] ? 2 : 0);
      end
      reg_write(A_FMT, 32'd13);
      reg_write(A_SIZE, 32'd4);

      // R2 R4 R6 chained descriptors with ready gaps
      rdy_all = 1'b0;
      put_desc(32'h20, 32'h100, 32'h1, 32'h40);
      put_desc(32'h40, 32'h200, 32'h1, 32'h41);
      reg_write(A_HEAD, 32'h20);
      p0 = pix_n; r0 = req_n;
      reg_write(A_CMD, 32'h1);
      wait_idle("R6 idle");
      rdy_all = 1'b1;
      chk("R2 fetch addr word", req_log[r0], 32'h20);
      chk("R2 fetch ctrl word", req_log[r0 + 1], 32'h24);
      chk("R2 fetch next word", req_log[r0 + 2], 32'h28);
      chk("R2 first buffer read", req_log[r0 + 3], 32'h100);
      chk("R4 follow next pointer", req_log[r0 + 7], 32'h40);
      chk("R6 total words", pix_n - p0, 8);
      for (int k = 0; k < 4; k++) begin
         chk("R2 frame word", pix_log[p0 + k], mem[64 + k]);
         chk("R4 second frame word", pix_log[p0 + 4 + k], mem[128 + k]);
      end
      reg_read(A_FLAG, v); chk("R6 flags", v, 32'h0B);

      // R5 run bit clear
      put_desc(32'h60, 32'h100, 32'h0, 32'h20);
      reg_write(A_HEAD, 32'h60);
      p0 = pix_n;
      reg_write(A_CMD, 32'h1);
      wait_idle("R5 idle");
      chk("R5 one frame", pix_n - p0, 4);
      reg_read(A_FLAG, v); chk("R5 flags", v, 32'h0B);

      // R7 stop after frame on a self-looping descriptor
      put_desc(32'h70, 32'h100, 32'h1, 32'h70);
      reg_write(A_HEAD, 32'h70);
      p0 = pix_n;
      reg_write(A_CMD, 32'h1);
      wait_pix(p0 + 1);
      reg_write(A_CMD, 32'h2);
      wait_idle("R7 idle");
      chk("R7 frame completes", pix_n - p0, 4);
      reg_read(A_FLAG, v); chk("R7 flags", v, 32'h0B);

      // R9 link a new descriptor during a frame
      put_desc(32'h90, 32'h200, 32'h0, 32'h0);
      p0 = pix_n; r0 = req_n;
      reg_write(A_CMD, 32'h1);
      wait_pix(p0 + 1);
      reg_write(A_HEAD, 32'h90);
      reg_write(A_CMD, 32'h8);
      wait_idle("R9 idle");
      chk("R9 words", pix_n - p0, 8);
      chk("R9 switch at boundary", req_log[r0 + 7], 32'h90);
      chk("R9 old frame intact", pix_log[p0 + 3], mem[67]);
      chk("R9 new frame", pix_log[p0 + 4], mem[128]);
      reg_read(A_FLAG, v); chk("R9 flags", v, 32'h0F);
      reg_write(A_CMD, 32'h8);
      reg_read(A_FLAG, v); chk("R9 link while idle", v, 0);
      reg_read(A_STAT, v); chk("R9 idle after link", v, 0);

      // R8 immediate kill with a read outstanding
      lat_cfg = 20;
      reg_write(A_HEAD, 32'h70);
      reg_write(A_CMD, 32'h1);
      do @(negedge clk); while (!(mem_req_valid && mem_req_ready && mem_req_addr[9:8] != 2'b00));
      p0 = pix_n;
      reg_write(A_CMD, 32'h4);
      reg_read(A_STAT, v); chk("R8 busy while draining", v, 1);
      wait_idle("R8 idle");
      repeat (5) @(negedge clk);
      chk("R8 dropped word not output", pix_n - p0, 0);
      reg_read(A_FLAG, v); chk("R8 flags no terminate", v, 32'h02);
      lat_cfg = 1;

      // R11 R10 interrupt masking and clear on read
      reg_write(A_HEAD, 32'h60);
      reg_write(A_CMD, 32'h1);
      wait_idle("R11 idle");
      chk("R11 irq masked", {31'd0, irq}, 0);
      reg_write(A_MASK, 32'h08);
      chk("R11 irq unmasked", {31'd0, irq}, 1);
      reg_read(A_MASK, v); chk("R13 mask readback", v, 32'h08);
      reg_read(A_FLAG, v); chk("R10 flags before clear", v, 32'h0B);
      chk("R11 irq after clear", {31'd0, irq}, 0);
      reg_read(A_FLAG, v); chk("R10 flags after clear", v, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule